// File: doc/BRIEF.md
# Prioritized Data Channel Service Engine

This block answers service requests that devices raise on an eight-level prioritized IO bus. It watches the request lines, grants one level at a time with the lowest-numbered level winning, and reads the word that the granted device drives onto the data lines. Bit 7 of that word marks a channel request. Bits 6:0 carry the device address.

A request without the channel flag goes to the core as a one-cycle interrupt pulse tagged with the device address. A channel request selects an entry in a per-device table, indexed by the low address bits. Each entry holds a transfer mode, a byte counter and a byte address. The engine then does one of four things:
- output: send a memory byte to the device;
- input: store the device byte in memory;
- add-in: add the device byte to the memory byte, write the sum back and return it to the device;
- count-only: move no data.

Every transferred byte decrements the counter and increments the address. Exhausting the counter raises a channel overflow pulse that tells the device to stop. A carry out of an add-in sets a sticky flag that the core clears.

The core loads table entries through a configuration write port. Memory is reached through a plain synchronous port with a one-cycle read latency.

Top module: `prio_chan_engine`

## Requirements
- R1: When one or more request lines are high and no grant is active, exactly one grant line rises, namely the one of the lowest-numbered pending level. At most one grant line is ever high.
- R2: A grant stays on its level, whatever other levels request, until that level's request drops. Arbitration then restarts.
- R3: In the cycle after the grant rises, the block samples the data lines. Bit 7 = 1 means a channel request; bits 6:0 are the device address, and their low three bits index the table. With bit 7 = 0, `intValid` pulses for one cycle with `intAddr` equal to bits 6:0, and no memory write and no device strobe occur.
- R4: Mode code 0 (output) reads the byte at the entry's address and presents it on `devDataOut` with a one-cycle `devStrobe`.
- R5: Mode code 1 (input) writes `devDataIn` to memory at the entry's address, with exactly one write and no strobe.
- R6: Mode code 2 (add-in) writes the 8-bit sum of the memory byte and `devDataIn` back to the same address and returns that sum on `devDataOut` with `devStrobe`.
- R7: A carry out of an add-in sets `addOvf`. It stays set until `addOvfClr` is pulsed. A set in the same cycle as a clear wins.
- R8: Mode code 3 (count-only) advances the counter and address without any memory write or strobe.
- R9: Each serviced byte decrements the entry's counter and increments its address, so the next request from that device uses the following address.
- R10: `chanOvf` pulses for one cycle when a counter goes from 1 to 0. A channel request that finds its counter already at 0 also pulses `chanOvf`, but moves no data and leaves the entry unchanged.
- R11: After reset, all grant lines, `devStrobe`, `chanOvf`, `intValid` and `addOvf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqLines | input | 8 | Priority request lines, level 0 highest |
| grantLines | output | 8 | Priority grant lines, one-hot or zero |
| busDataIn | input | 8 | Data lines from the granted device: channel flag and address |
| devDataIn | input | 8 | Byte supplied by the device for input and add-in |
| devDataOut | output | 8 | Byte returned to the device |
| devStrobe | output | 1 | One-cycle valid for devDataOut |
| chanOvf | output | 1 | One-cycle channel overflow (end of transfer) to the device |
| intValid | output | 1 | One-cycle plain interrupt to the core |
| intAddr | output | 7 | Device address of the interrupt |
| addOvf | output | 1 | Sticky add overflow status |
| addOvfClr | input | 1 | Clears addOvf |
| cfgWe | input | 1 | Table entry write enable |
| cfgDev | input | 3 | Table entry index |
| cfgMode | input | 2 | Transfer mode code to load |
| cfgCount | input | 8 | Byte counter to load |
| cfgAddr | input | 8 | Byte address to load |
| memAddr | output | 8 | Memory address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, one cycle after memAddr |

## Verification
The transfer sequence is tried with each of the four mode codes from a range of request levels. This separates a wrong mode decode from a wrong arbitration result. Repeated requests from one device show whether the address really advances and whether the counter ends in an overflow on the right byte. An entry that starts at zero shows that an exhausted channel moves nothing. Two add-ins, one without a carry and one with, distinguish the sum path from the sticky carry. A request without the flag distinguishes the interrupt path from channel service. Overlapping requests at three levels show lowest-number priority and a grant held while a more urgent level waits.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic [1:0] {
    MODE_OUT = 2'd0,
    MODE_IN  = 2'd1,
    MODE_ADD = 2'd2,
    MODE_CNT = 2'd3
  } xferMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // sample data lines
    logic wrIn;      // write device byte to memory
    logic wrSum;     // write sum to memory
    logic sendByte;  // present byte to device
    logic advance;   // step counter and address
    logic exhaust;   // counter already empty
  } strobes_t;
endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] reqLines,
  input  logic              busFlag,
  input  xferMode_e         curMode,
  input  logic              curZero,
  output logic [LEVELS-1:0] grantLines,
  output strobes_t          strb
);
  localparam int LVL_W = $clog2(LEVELS);

  typedef enum logic [2:0] {S_IDLE, S_GRANT, S_EXEC, S_WAIT, S_HOLD} state_e;
  state_e state, stateNext;
  logic [LVL_W-1:0] grantLvl, pickLvl;

  always_comb begin
    pickLvl = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (reqLines[i]) pickLvl = LVL_W'(i);
    end
  end

  assign grantLines = (state != S_IDLE) ? (LEVELS'(1) << grantLvl) : '0;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      S_IDLE:  if (|reqLines) stateNext = S_GRANT;
      S_GRANT: begin
        strb.capture = 1'b1;
        stateNext    = busFlag ? S_EXEC : S_HOLD;
      end
      S_EXEC: begin
        stateNext = S_HOLD;
        if (curZero) begin
          strb.exhaust = 1'b1;
        end else begin
          case (curMode)
            MODE_IN:  begin strb.wrIn = 1'b1; strb.advance = 1'b1; end
            MODE_CNT: strb.advance = 1'b1;
            default:  stateNext = S_WAIT;
          endcase
        end
      end
      S_WAIT: begin
        strb.sendByte = 1'b1;
        strb.advance  = 1'b1;
        strb.wrSum    = (curMode == MODE_ADD);
        stateNext     = S_HOLD;
      end
      S_HOLD:  if (!reqLines[grantLvl]) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      grantLvl <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE) grantLvl <= pickLvl;
    end
  end
endmodule

// File: rtl/pce_dpath.sv
module pce_dpath
  import pce_pkg::*;
#(
  parameter int DEV_W = 3,
  parameter int AW    = 8,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobes_t         strb,
  input  logic [7:0]       busDataIn,
  input  logic [7:0]       devDataIn,
  input  logic [7:0]       memRdata,
  input  logic             cfgWe,
  input  logic [DEV_W-1:0] cfgDev,
  input  xferMode_e        cfgMode,
  input  logic [CW-1:0]    cfgCount,
  input  logic [AW-1:0]    cfgAddr,
  input  logic             addOvfClr,
  output xferMode_e        curMode,
  output logic             curZero,
  output logic [AW-1:0]    memAddr,
  output logic             memWe,
  output logic [7:0]       memWdata,
  output logic [7:0]       devDataOut,
  output logic             devStrobe,
  output logic             chanOvf,
  output logic             intValid,
  output logic [6:0]       intAddr,
  output logic             addOvf
);
  localparam int NDEV = 1 << DEV_W;

  xferMode_e     modeTab [NDEV];
  logic [CW-1:0] cntTab  [NDEV];
  logic [AW-1:0] addrTab [NDEV];
  logic [6:0]    capAddr;
  logic [DEV_W-1:0] idx;
  logic [8:0]    sum9;

  assign idx      = capAddr[DEV_W-1:0];
  assign curMode  = modeTab[idx];
  assign curZero  = (cntTab[idx] == '0);
  assign memAddr  = addrTab[idx];
  assign sum9     = {1'b0, memRdata} + {1'b0, devDataIn};
  assign memWe    = strb.wrIn | strb.wrSum;
  assign memWdata = strb.wrSum ? sum9[7:0] : devDataIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NDEV; d++) begin
        modeTab[d] <= MODE_OUT;
        cntTab[d]  <= '0;
        addrTab[d] <= '0;
      end
    end else begin
      if (cfgWe) begin
        modeTab[cfgDev] <= cfgMode;
        cntTab[cfgDev]  <= cfgCount;
        addrTab[cfgDev] <= cfgAddr;
      end
      if (strb.advance) begin
        cntTab[idx]  <= cntTab[idx] - CW'(1);
        addrTab[idx] <= addrTab[idx] + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capAddr    <= '0;
      intValid   <= 1'b0;
      intAddr    <= '0;
      devStrobe  <= 1'b0;
      devDataOut <= '0;
      chanOvf    <= 1'b0;
      addOvf     <= 1'b0;
    end else begin
      intValid  <= strb.capture & ~busDataIn[7];
      devStrobe <= strb.sendByte;
      chanOvf   <= strb.exhaust | (strb.advance & (cntTab[idx] == CW'(1)));
      if (strb.capture) begin
        capAddr <= busDataIn[6:0];
        intAddr <= busDataIn[6:0];
      end
      if (strb.sendByte) devDataOut <= strb.wrSum ? sum9[7:0] : memRdata;
      if (strb.wrSum && sum9[8]) addOvf <= 1'b1;
      else if (addOvfClr)        addOvf <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_chan_engine.sv
module prio_chan_engine
  import pce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reqLines,
  output logic [7:0] grantLines,
  input  logic [7:0] busDataIn,
  input  logic [7:0] devDataIn,
  output logic [7:0] devDataOut,
  output logic       devStrobe,
  output logic       chanOvf,
  output logic       intValid,
  output logic [6:0] intAddr,
  output logic       addOvf,
  input  logic       addOvfClr,
  input  logic       cfgWe,
  input  logic [2:0] cfgDev,
  input  logic [1:0] cfgMode,
  input  logic [7:0] cfgCount,
  input  logic [7:0] cfgAddr,
  output logic [7:0] memAddr,
  output logic       memWe,
  output logic [7:0] memWdata,
  input  logic [7:0] memRdata
);
  strobes_t  strb;
  xferMode_e curMode;
  logic      curZero;

  pce_ctrl #(.LEVELS(8)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqLines(reqLines), .busFlag(busDataIn[7]),
    .curMode(curMode), .curZero(curZero), .grantLines(grantLines), .strb(strb)
  );

  pce_dpath #(.DEV_W(3), .AW(8), .CW(8)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busDataIn(busDataIn),
    .devDataIn(devDataIn), .memRdata(memRdata), .cfgWe(cfgWe), .cfgDev(cfgDev),
    .cfgMode(xferMode_e'(cfgMode)), .cfgCount(cfgCount), .cfgAddr(cfgAddr),
    .addOvfClr(addOvfClr), .curMode(curMode), .curZero(curZero),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .devDataOut(devDataOut), .devStrobe(devStrobe), .chanOvf(chanOvf),
    .intValid(intValid), .intAddr(intAddr), .addOvf(addOvf)
  );
endmodule

// File: rtl/pce_checker.sv
module pce_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reqLines,
  input logic [7:0] grantLines,
  input logic       devStrobe,
  input logic       chanOvf,
  input logic       intValid,
  input logic       addOvf,
  input logic       addOvfClr,
  input logic       memWe
);
  a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantLines));

  a_r2_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((reqLines & grantLines) != 8'h00) |=> (grantLines == $past(grantLines)));

  a_r3_int_no_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    intValid |-> (!memWe && !devStrobe));

  a_r4_strobe_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
    devStrobe |-> (grantLines != 8'h00));

  a_r5_write_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (grantLines != 8'h00));

  a_r7_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (addOvf && !addOvfClr) |=> addOvf);

  a_r10_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    chanOvf |=> !chanOvf);
endmodule

bind prio_chan_engine pce_checker chk_i (
  .clk(clk), .rst_n(rst_n), .reqLines(reqLines), .grantLines(grantLines),
  .devStrobe(devStrobe), .chanOvf(chanOvf), .intValid(intValid),
  .addOvf(addOvf), .addOvfClr(addOvfClr), .memWe(memWe)
);

// File: tb/prio_chan_engine_tb_top.sv
module prio_chan_engine_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n;
  logic [7:0] reqLines, grantLines, busDataIn, devDataIn, devDataOut;
  logic devStrobe, chanOvf, intValid, addOvf, addOvfClr, cfgWe, memWe;
  logic [6:0] intAddr;
  logic [2:0] cfgDev;
  logic [1:0] cfgMode;
  logic [7:0] cfgCount, cfgAddr, memAddr, memWdata, memRdata;

  prio_chan_engine dut_i (.*);

  logic [7:0] mem [256];
  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  int nChecks = 0, nFail = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] lvl;  logic flag; logic [6:0] dev; logic [7:0] din;
    logic st; logic [7:0] out; logic ov; logic it; logic [3:0] wr;
    logic mc; logic [7:0] ma; logic [7:0] mv;
  } vec_t;

  // mode codes: 0 out, 1 in, 2 add-in, 3 count-only
  localparam vec_t VECS [11] = '{
    '{3'd2,1'b1,7'h00,8'h00,1'b1,8'h5A,1'b0,1'b0,4'd0,1'b1,8'h10,8'h5A}, // R4
    '{3'd5,1'b1,7'h00,8'h00,1'b1,8'hC3,1'b0,1'b0,4'd0,1'b0,8'h00,8'h00}, // R9
    '{3'd1,1'b1,7'h01,8'hA7,1'b0,8'h00,1'b0,1'b0,4'd1,1'b1,8'h20,8'hA7}, // R5
    '{3'd1,1'b1,7'h01,8'h3C,1'b0,8'h00,1'b1,1'b0,4'd1,1'b1,8'h21,8'h3C}, // R5 R10
    '{3'd3,1'b1,7'h01,8'hFF,1'b0,8'h00,1'b1,1'b0,4'd0,1'b1,8'h22,8'h00}, // R10 empty
    '{3'd0,1'b1,7'h02,8'h05,1'b1,8'h75,1'b0,1'b0,4'd1,1'b1,8'h30,8'h75}, // R6
    '{3'd4,1'b1,7'h02,8'h20,1'b1,8'h10,1'b0,1'b0,4'd1,1'b1,8'h31,8'h10}, // R6 carry
    '{3'd6,1'b1,7'h03,8'h00,1'b0,8'h00,1'b1,1'b0,4'd0,1'b1,8'h40,8'h00}, // R8
    '{3'd7,1'b0,7'h55,8'h00,1'b0,8'h00,1'b0,1'b1,4'd0,1'b0,8'h00,8'h00}, // R3
    '{3'd2,1'b1,7'h04,8'h00,1'b0,8'h00,1'b1,1'b0,4'd0,1'b1,8'h50,8'h99}, // R10
    '{3'd0,1'b1,7'h00,8'h00,1'b1,8'h66,1'b1,1'b0,4'd0,1'b0,8'h00,8'h00}  // R9 R10
  };

  task automatic loadEntry(logic [2:0] d, logic [1:0] m, logic [7:0] c, logic [7:0] a);
    @(negedge clk);
    cfgWe = 1'b1; cfgDev = d; cfgMode = m; cfgCount = c; cfgAddr = a;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic serve(vec_t v);
    bit gotG = 0, st = 0, ov = 0, it = 0;
    logic [7:0] g = '0, out = '0;
    logic [6:0] ia = '0;
    int wr = 0;
    @(negedge clk);
    reqLines  = 8'h01 << v.lvl;
    busDataIn = {v.flag, v.dev};
    devDataIn = v.din;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!gotG && grantLines != 0) begin gotG = 1; g = grantLines; end
      if (devStrobe) begin st = 1; out = devDataOut; end
      if (chanOvf) ov = 1;
      if (intValid) begin it = 1; ia = intAddr; end
      if (memWe) wr++;
    end
    reqLines = 8'h00;
    repeat (3) @(negedge clk);
    check(g == (8'h01 << v.lvl), "R1 grant", g, 8'h01 << v.lvl);
    check(st == v.st, "R4 strobe", st, v.st);
    if (v.st) check(out == v.out, "R6 byte to device", out, v.out);
    check(ov == v.ov, "R10 chanOvf", ov, v.ov);
    check(it == v.it, "R3 intValid", it, v.it);
    if (v.it) check(ia == v.dev, "R3 intAddr", ia, v.dev);
    check(wr == int'(v.wr), "R5 write count", wr, v.wr);
    if (v.mc) check(mem[v.ma] == v.mv, "R9 memory content", mem[v.ma], v.mv);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h10] = 8'h5A; mem[8'h11] = 8'hC3; mem[8'h12] = 8'h66;
    mem[8'h30] = 8'h70; mem[8'h31] = 8'hF0; mem[8'h50] = 8'h99;
    rst_n = 1'b0; reqLines = '0; busDataIn = '0; devDataIn = '0;
    addOvfClr = 1'b0; cfgWe = 1'b0; cfgDev = '0; cfgMode = '0;
    cfgCount = '0; cfgAddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(grantLines == 0, "R11 grants", grantLines, 0);
    check({devStrobe, chanOvf, intValid, addOvf} == 0, "R11 flags",
          {devStrobe, chanOvf, intValid, addOvf}, 0);

    loadEntry(3'd0, 2'd0, 8'd3, 8'h10);
    loadEntry(3'd1, 2'd1, 8'd2, 8'h20);
    loadEntry(3'd2, 2'd2, 8'd4, 8'h30);
    loadEntry(3'd3, 2'd3, 8'd1, 8'h40);
    loadEntry(3'd4, 2'd0, 8'd0, 8'h50);

    for (int i = 0; i < 11; i++) begin
      serve(VECS[i]);
      // R7: no carry before vector 6, sticky after
      check(addOvf == (i >= 6), "R7 addOvf", addOvf, i >= 6);
    end

    // R7 clear
    @(negedge clk); addOvfClr = 1'b1;
    @(negedge clk); addOvfClr = 1'b0;
    check(addOvf == 1'b0, "R7 clear", addOvf, 0);

    // R1 priority among levels 3 and 6, R2 hold while level 1 waits
    @(negedge clk);
    busDataIn = 8'h01; reqLines = 8'b0100_1000;
    repeat (3) @(negedge clk);
    check(grantLines == 8'h08, "R1 lowest level wins", grantLines, 8'h08);
    reqLines = 8'b0100_1010;
    repeat (3) @(negedge clk);
    check(grantLines == 8'h08, "R2 grant held", grantLines, 8'h08);
    reqLines = 8'b0100_0010;
    repeat (3) @(negedge clk);
    check(grantLines == 8'h02, "R2 re-arbitrate", grantLines, 8'h02);
    reqLines = 8'h00;
    repeat (3) @(negedge clk);
    check(grantLines == 8'h00, "R2 release", grantLines, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule